// File: doc/BRIEF.md
# Sensor Ring Thermal Controller

This block is the master of a daisy-chained ring of on-die temperature nodes that share one serial wire. It injects command frames into the first node of the ring and receives frames from the last node. A Sense pass makes every node take a reading and latch it with its own ID. A Read pass then shifts the latched frames around the ring, one node per read cycle. The controller decodes each returned frame and finds the node's slot from its ID. It corrects the reading by a signed offset, which stands for the gap between an external reference sensor and the internal ones. The result is held in a staging table.

When the Read pass completes, the staged temperatures are committed to the result table in one cycle. Each slot's cooler-enable output is then recomputed against a threshold, with a small hysteresis band. The cooler of a slot is the one nearest that node's hot spot.

A full cycle starts by itself after reset. It repeats after a programmable idle interval. A malformed return or a silent ring aborts the pass and raises an error flag.

Top module: `therm_ring_ctrl`

States:
- `ST_IDLE`: counts down the interval.
- `ST_SENSE_TX`: loads the Sense frame into the transmitter.
- `ST_SENSE_WAIT`: waits for the frame of the last node.
- `ST_READ_TX`: loads one Read frame.
- `ST_READ_WAIT`: waits for one returned frame.
- `ST_COMMIT`: copies the staging table and updates the coolers.

Transitions:
- `ST_IDLE` to `ST_SENSE_TX` when the interval count is zero.
- `ST_SENSE_TX` to `ST_SENSE_WAIT` unconditionally.
- `ST_SENSE_WAIT` to `ST_READ_TX` on a frame with a known ID.
- `ST_READ_TX` to `ST_READ_WAIT` unconditionally.
- `ST_READ_WAIT` to `ST_READ_TX` on a known-ID frame.
- `ST_READ_WAIT` to `ST_COMMIT` on the all-zero frame.
- `ST_COMMIT` to `ST_IDLE` unconditionally.
- Either wait state to `ST_IDLE` (abort) on an unknown ID, on too many frames, or on a timeout.

## Requirements
- R1: After reset is released the controller starts a cycle with no other input: the first frame on `line_o` is a Sense frame with zero ID and zero data.
- R2: Line format. The line idles low. A frame is one start bit of 1 followed by 14 bits, MSB first: command bit (1 = Sense, 0 = Read), two header bits of 0, a 3-bit ID and 8-bit data. One bit is sent per clock.
- R3: A Sense pass ends when one frame returns. That frame is the last node's reading and is staged like any other reading.
- R4: The Read pass sends only all-zero Read frames, one for each returned frame. It ends when the all-zero Read frame returns. A nonzero frame after N readings aborts the pass.
- R5: Each staged value is the 8-bit reading plus the signed 8-bit `ofs_i`, saturated to 0 and to 255.
- R6: At commit a cooler turns on when its value is above `thr_i`. It turns off only when the value is below `thr_i` minus 2. Otherwise it keeps its state.
- R7: Node IDs 0, 2, 3 and 7 map to slot and cooler bits 0, 1, 2 and 3. `rd_temp_o` shows the committed value of slot `rd_sel_i` combinationally.
- R8: A returned frame with an ID not in the map sets `err_o` and aborts to idle. The result table and the cooler enables are left unchanged.
- R9: If no start bit arrives within 64 clocks after the controller's frame has gone out, `err_o` is set and the pass aborts.
- R10: The table and the cooler enables change only at commit. Commit is marked by a one-clock `done_o` pulse and clears `err_o`.
- R11: After commit or abort the controller idles. The next Sense start bit appears `ival_i`+3 clocks after the `done_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock, one bit period per cycle |
| rst_n | input | 1 | active-low asynchronous reset |
| line_i | input | 1 | serial line from the last node |
| line_o | output | 1 | serial line to the first node |
| ofs_i | input | 8 | signed compensation offset |
| thr_i | input | 8 | cooler threshold |
| ival_i | input | 16 | idle interval in clocks |
| rd_sel_i | input | 2 | result table slot to show |
| rd_temp_o | output | 8 | committed value of the selected slot |
| cool_en_o | output | 4 | one cooler enable per slot |
| err_o | output | 1 | sticky pass error, cleared at commit |
| done_o | output | 1 | one-clock commit pulse |

## Verification
The hardest cases to reach are a pass that fails midway and hysteresis decisions that depend on the previous cycle. The bench contains a behavioural model of the ring: four nodes, each holding an ID, a temperature and a shift register. It reprograms the model between cycles, during the idle window. To create failures it renames one node to an unmapped ID, and later silences the whole ring. For the hysteresis, the stimulus vectors are ordered so that each one inherits cooler states from the one before.

// File: rtl/therm_ring_pkg.sv
package therm_ring_pkg;
    localparam int ID_W    = 3;
    localparam int DATA_W  = 8;
    localparam int HDR_W   = 2;
    localparam int FRAME_W = 1 + HDR_W + ID_W + DATA_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SENSE_TX,
        ST_SENSE_WAIT,
        ST_READ_TX,
        ST_READ_WAIT,
        ST_COMMIT
    } ring_state_e;
endpackage

// File: rtl/ring_tx.sv
module ring_tx
    import therm_ring_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame,
    output logic               busy,
    output logic               line
);
    localparam int CNT_W = $clog2(FRAME_W + 2);

    logic [FRAME_W:0] shreg;
    logic [CNT_W-1:0] cnt;

    assign busy = (cnt != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            cnt   <= '0;
            line  <= 1'b0;
        end else if (start) begin
            shreg <= {1'b1, frame};
            cnt   <= CNT_W'(FRAME_W + 1);
            line  <= 1'b0;
        end else if (busy) begin
            line  <= shreg[FRAME_W];
            shreg <= shreg << 1;
            cnt   <= cnt - 1'b1;
        end else begin
            line  <= 1'b0;
        end
    end
endmodule

// File: rtl/ring_rx.sv
module ring_rx
    import therm_ring_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line,
    output logic               busy,
    output logic               valid,
    output logic [FRAME_W-1:0] frame
);
    localparam int CNT_W = $clog2(FRAME_W + 2);

    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   cnt;

    assign busy = (cnt != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            cnt   <= '0;
            valid <= 1'b0;
            frame <= '0;
        end else begin
            valid <= 1'b0;
            if (!busy) begin
                if (line) cnt <= CNT_W'(FRAME_W);
            end else begin
                shreg <= {shreg[FRAME_W-2:0], line};
                cnt   <= cnt - 1'b1;
                if (cnt == CNT_W'(1)) begin
                    valid <= 1'b1;
                    frame <= {shreg[FRAME_W-2:0], line};
                end
            end
        end
    end
endmodule

// File: rtl/temp_comp.sv
module temp_comp #(
    parameter int W = 8
) (
    input  logic [W-1:0] raw,
    input  logic [W-1:0] ofs,
    output logic [W-1:0] corr
);
    logic signed [W+1:0] sum;

    always_comb begin
        sum = $signed({2'b00, raw}) + $signed({{2{ofs[W-1]}}, ofs});
        if (sum < 0)
            corr = '0;
        else if (sum > $signed((W+2)'((1 << W) - 1)))
            corr = '1;
        else
            corr = sum[W-1:0];
    end
endmodule

// File: rtl/cool_hyst.sv
module cool_hyst #(
    parameter int W    = 8,
    parameter int BAND = 2
) (
    input  logic [W-1:0] val,
    input  logic [W-1:0] thr,
    input  logic         cur_en,
    output logic         nxt_en
);
    logic above, below;

    assign above  = val > thr;
    assign below  = ({1'b0, val} + (W+1)'(BAND)) < {1'b0, thr};
    assign nxt_en = above | (cur_en & ~below);
endmodule

// File: rtl/therm_ring_ctrl.sv
module therm_ring_ctrl
    import therm_ring_pkg::*;
#(
    parameter int                  N       = 4,
    parameter logic [N*ID_W-1:0]   ID_MAP  = {3'd7, 3'd3, 3'd2, 3'd0},
    parameter int                  TMO     = 64,
    parameter int                  BAND    = 2,
    parameter int                  IVAL_W  = 16,
    localparam int                 SEL_W   = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_i,
    output logic              line_o,
    input  logic [DATA_W-1:0] ofs_i,
    input  logic [DATA_W-1:0] thr_i,
    input  logic [IVAL_W-1:0] ival_i,
    input  logic [SEL_W-1:0]  rd_sel_i,
    output logic [DATA_W-1:0] rd_temp_o,
    output logic [N-1:0]      cool_en_o,
    output logic              err_o,
    output logic              done_o
);
    localparam int TMO_W = $clog2(TMO + 1);
    localparam int RC_W  = $clog2(N + 1);

    ring_state_e state, state_nx;

    logic               tx_start, tx_busy, rx_busy, rx_valid;
    logic [FRAME_W-1:0] tx_frame, rx_frame;
    logic [DATA_W-1:0]  stage [N];
    logic [DATA_W-1:0]  table_q [N];
    logic [N-1:0]       cool_nx;
    logic [DATA_W-1:0]  corr;
    logic [TMO_W-1:0]   tmo;
    logic [RC_W-1:0]    rcnt;
    logic [IVAL_W-1:0]  icnt;
    logic               hit, timeout, waiting, zero_frame;
    logic [SEL_W-1:0]   slot;

    assign tx_start = (state == ST_SENSE_TX) || (state == ST_READ_TX);
    assign tx_frame = {(state == ST_SENSE_TX), {(FRAME_W-1){1'b0}}};

    ring_tx u_tx (.clk, .rst_n, .start(tx_start), .frame(tx_frame),
                  .busy(tx_busy), .line(line_o));
    ring_rx u_rx (.clk, .rst_n, .line(line_i), .busy(rx_busy),
                  .valid(rx_valid), .frame(rx_frame));
    temp_comp #(.W(DATA_W)) u_comp (.raw(rx_frame[DATA_W-1:0]), .ofs(ofs_i), .corr);

    for (genvar g = 0; g < N; g++) begin : g_hyst
        cool_hyst #(.W(DATA_W), .BAND(BAND)) u_hyst (
            .val(stage[g]), .thr(thr_i), .cur_en(cool_en_o[g]), .nxt_en(cool_nx[g]));
    end

    always_comb begin
        hit  = 1'b0;
        slot = '0;
        for (int i = 0; i < N; i++) begin
            if (ID_MAP[i*ID_W +: ID_W] == rx_frame[DATA_W +: ID_W]) begin
                hit  = 1'b1;
                slot = SEL_W'(i);
            end
        end
    end

    assign zero_frame = (rx_frame == '0);
    assign waiting    = (state == ST_SENSE_WAIT) || (state == ST_READ_WAIT);
    assign timeout    = waiting && !rx_valid && (tmo == TMO_W'(TMO - 1));
    assign rd_temp_o  = table_q[rd_sel_i];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:       if (icnt == '0) state_nx = ST_SENSE_TX;
            ST_SENSE_TX:   state_nx = ST_SENSE_WAIT;
            ST_SENSE_WAIT: begin
                if (rx_valid)     state_nx = hit ? ST_READ_TX : ST_IDLE;
                else if (timeout) state_nx = ST_IDLE;
            end
            ST_READ_TX:    state_nx = ST_READ_WAIT;
            ST_READ_WAIT: begin
                if (rx_valid) begin
                    if (zero_frame)                          state_nx = ST_COMMIT;
                    else if (hit && rcnt < RC_W'(N))         state_nx = ST_READ_TX;
                    else                                     state_nx = ST_IDLE;
                end else if (timeout) state_nx = ST_IDLE;
            end
            ST_COMMIT:     state_nx = ST_IDLE;
            default:       state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                stage[i]   <= '0;
                table_q[i] <= '0;
            end
            cool_en_o <= '0;
            err_o     <= 1'b0;
            done_o    <= 1'b0;
            tmo       <= '0;
            rcnt      <= '0;
            icnt      <= '0;
        end else begin
            done_o <= 1'b0;
            if (tx_start || rx_busy || rx_valid) tmo <= '0;
            else if (waiting && !tx_busy)        tmo <= tmo + 1'b1;
            if (state == ST_IDLE && icnt != '0) icnt <= icnt - 1'b1;
            if (state_nx == ST_IDLE && state != ST_IDLE) icnt <= ival_i;
            if (state == ST_SENSE_TX) rcnt <= '0;
            if (waiting && (timeout || (state_nx == ST_IDLE))) err_o <= 1'b1;
            if (waiting && rx_valid && hit && !zero_frame && state_nx == ST_READ_TX) begin
                stage[slot] <= corr;
                if (state == ST_READ_WAIT) rcnt <= rcnt + 1'b1;
            end
            if (state == ST_COMMIT) begin
                for (int i = 0; i < N; i++) table_q[i] <= stage[i];
                cool_en_o <= cool_nx;
                done_o    <= 1'b1;
                err_o     <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/therm_ring_ctrl_chk.sv
module therm_ring_ctrl_chk
    import therm_ring_pkg::*;
#(
    parameter int N = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              line_o,
    input logic [DATA_W-1:0] thr_i,
    input logic [N-1:0]      cool_en_o,
    input logic              err_o,
    input logic              done_o,
    input ring_state_e       state,
    input logic [DATA_W-1:0] table_q [N]
);
    // R10
    cool_commit_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cool_en_o) |-> done_o);

    // R10
    done_clears_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !err_o);

    // R2
    line_idle_at_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !line_o);

    // R8
    abort_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> state == ST_IDLE);

    for (genvar g = 0; g < N; g++) begin : g_cool
        // R6
        cool_on_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(cool_en_o[g]) |-> table_q[g] > thr_i);
        // R6
        cool_off_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(cool_en_o[g]) |-> ({1'b0, table_q[g]} + 9'd2) < {1'b0, thr_i});
    end
endmodule

bind therm_ring_ctrl therm_ring_ctrl_chk #(.N(N)) u_chk (
    .clk(clk), .rst_n(rst_n), .line_o(line_o), .thr_i(thr_i),
    .cool_en_o(cool_en_o), .err_o(err_o), .done_o(done_o),
    .state(state), .table_q(table_q));

// File: tb/test_therm_ring_ctrl.sv
module test_therm_ring_ctrl;
    localparam int FW = 14;
    localparam int NN = 4;
    localparam logic [2:0] IDS [NN] = '{3'd0, 3'd2, 3'd3, 3'd7};
    // t0, t1, t2, t3, offset, expected cooler mask
    localparam logic [47:0] VEC [4] = '{
        {8'd50, 8'd101, 8'd100, 8'd200, 8'h00, 8'b1010},
        {8'd99, 8'd99,  8'd98,  8'd97,  8'h00, 8'b0010},
        {8'd99, 8'd97,  8'd250, 8'd10,  8'h0A, 8'b0111},
        {8'd5,  8'd0,   8'd3,   8'd100, 8'hF6, 8'b0000}
    };

    logic clk = 0, rst_n = 0, line_i = 0, line_o;
    logic [7:0] ofs_i = 0, thr_i = 8'd100, rd_temp_o;
    logic [15:0] ival_i = 16'd200;
    logic [1:0] rd_sel_i = 0;
    logic [3:0] cool_en_o;
    logic err_o, done_o;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int rx_end_cyc = 0, bad_read = 0, n_frames = 0;
    logic [FW-1:0] first_frame = '0;
    logic [2:0] node_id [NN];
    logic [7:0] node_t [NN];
    logic [FW-1:0] node_r [NN];
    logic mute = 0;

    therm_ring_ctrl i_therm_ring_ctrl (.*);

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] sat(input logic [7:0] r, input logic [7:0] o);
        int s = int'(r) + int'($signed(o));
        return (s < 0) ? 8'd0 : (s > 255) ? 8'd255 : 8'(s);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // ring model
    initial begin
        logic [FW-1:0] f, rep;
        forever begin
            @(negedge clk);
            if (line_o === 1'b1) begin
                f = '0;
                for (int b = 0; b < FW; b++) begin
                    @(negedge clk);
                    f = {f[FW-2:0], line_o};
                end
                rx_end_cyc = cyc;
                if (n_frames == 0) first_frame = f;
                n_frames++;
                if (f[FW-1]) begin
                    for (int k = 0; k < NN; k++) node_r[k] = {1'b1, 2'b00, node_id[k], node_t[k]};
                    rep = node_r[NN-1];
                end else begin
                    if (f != '0) bad_read++;
                    rep = node_r[NN-1];
                    for (int k = NN-1; k > 0; k--) node_r[k] = node_r[k-1];
                    node_r[0] = f;
                end
                if (!mute) begin
                    repeat (3) @(negedge clk);
                    line_i = 1'b1;
                    for (int b = FW-1; b >= 0; b--) begin
                        @(negedge clk);
                        line_i = rep[b];
                    end
                    @(negedge clk);
                    line_i = 1'b0;
                end
            end
        end
    end

    always @(posedge clk) if (cyc > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=0", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    task automatic load_vec(input int v);
        for (int k = 0; k < NN; k++) node_t[k] = VEC[v][47 - 8*k -: 8];
        ofs_i = VEC[v][15:8];
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!done_o);
    endtask

    task automatic check_table(input string req, input logic [7:0] e [NN]);
        for (int k = 0; k < NN; k++) begin
            rd_sel_i = 2'(k);
            #1;
            chk(req, rd_temp_o, e[k]);
        end
    endtask

    initial begin
        logic [7:0] e [NN];
        int t0, dt;
        for (int k = 0; k < NN; k++) begin node_id[k] = IDS[k]; node_r[k] = '0; end
        load_vec(0);
        repeat (4) @(negedge clk);
        // reset state
        chk("R10 reset cool", cool_en_o, 0);
        chk("R10 reset err", err_o, 0);
        chk("R2 reset line idle", line_o, 0);
        chk("R10 reset done", done_o, 0);
        rst_n = 1;
        for (int v = 0; v < 4; v++) begin
            wait_done();
            if (v == 0) chk("R1 first frame is zero Sense", first_frame, 14'h2000);
            for (int k = 0; k < NN; k++) e[k] = sat(VEC[v][47 - 8*k -: 8], VEC[v][15:8]);
            check_table("R5 R7 table value", e);
            chk("R6 R7 cooler mask", cool_en_o, VEC[v][3:0]);
            chk("R3 R4 frames per cycle", n_frames, 6 * (v + 1));
            if (v < 3) load_vec(v + 1);
        end
        chk("R4 read frames all zero", bad_read, 0);
        // R11 interval
        t0 = cyc;
        do @(negedge clk); while (line_o !== 1'b1);
        chk("R11 interval", cyc - t0, 200 + 3);
        wait_done();
        // R8 unknown ID
        for (int k = 0; k < NN; k++) node_t[k] = 8'd200;
        node_id[2] = 3'd5;
        do @(negedge clk); while (!err_o && !done_o);
        chk("R8 err on unknown id", err_o, 1);
        chk("R8 no commit", done_o, 0);
        e = '{8'd0, 8'd0, 8'd0, 8'd90};
        check_table("R8 table unchanged", e);
        chk("R8 cool unchanged", cool_en_o, 0);
        node_id[2] = 3'd3;
        wait_done();
        chk("R10 err cleared at commit", err_o, 0);
        e = '{8'd190, 8'd190, 8'd190, 8'd190};
        check_table("R10 table committed", e);
        chk("R6 all coolers on", cool_en_o, 4'hF);
        // R9 timeout
        mute = 1;
        do @(negedge clk); while (!err_o && !done_o);
        dt = cyc - rx_end_cyc;
        chk("R9 err on silence", err_o, 1);
        chk("R9 timeout window", (dt >= 63 && dt <= 66), 1);
        chk("R9 cool kept", cool_en_o, 4'hF);
        mute = 0;
        wait_done();
        chk("R9 recovery clears err", err_o, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule